// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

This block watches an 8-bit temperature code that a sensor front end presents with a one-cycle sample strobe. On each accepted sample the code is stored as the current temperature. The code is also compared against four packed rising thresholds and three packed falling thresholds. A rising level flags an event when the code first climbs to or above its threshold. A falling level flags an event when the code drops below its threshold after having been at or above it. Each event sets a sticky status bit. The single interrupt line is high while any status bit is set and also enabled.

Software reaches the block through a plain 32-bit register bus. Writes take effect on the clock edge; reads are combinational from the address. The bus gives access to the following:
- a control word: core enable, plus a mode, gain and reference-voltage field that are only stored;
- a ready flag;
- the current code;
- the two threshold words;
- the interrupt enable mask;
- the status word and a write-one-to-clear port.

An emulation register can substitute a programmed code for the sensor input after a programmed number of sample strobes. This lets the threshold logic be tested without heating the die.

Top module: `thermal_irq_monitor`

## Requirements
- R1: After reset, control, thresholds, enables, status and the current code read as zero, `irq` is low, and bit 0 of the ready register (offset 0x28) reads 1 from the first clock after reset.
- R2: While control bit 0 (core enable, offset 0x20) is 0, a sample strobe changes neither the current code (offset 0x40) nor the status word.
- R3: Control keeps only bit 0, bits [15:13], [11:8] and [28:24]; all other bits, bit 1 included, read as zero, so writing all ones reads back 0x1F00EF01.
- R4: With the core enabled, each sample strobe loads the effective code into the current code register, which is read as bits [7:0] of offset 0x40.
- R5: Rising level i (0..3) takes its threshold from bits [8i+7:8i] of offset 0x50. It sets status bit 4i on the sample where the code becomes greater than or equal to that threshold, having been below it on the previous sample or since reset. It does not set again while the code stays at or above the threshold.
- R6: Falling level j (0..2) takes its threshold from bits [8j+7:8j] of offset 0x54. It sets status bit 16+4j on the sample where the code drops below that threshold, having been at or above it on the previous sample.
- R7: `irq` is the OR of status AND enable (offset 0x70, same bit positions as status). Status bits latch even when their enable bit is clear.
- R8: Writing ones to offset 0x78 clears the matching status bits (offset 0x74). A status bit set by a sample in the same cycle stays set.
- R9: Emulation (offset 0x80) has enable at bit 0, code at [15:8] and delay D at [31:16]. After it is written with enable set, the first D enabled sample strobes use the sensor code and every later one uses the emulated code. Clearing enable returns to the sensor code at once.
- R10: Writes to the status offset have no effect, and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle strobe marking a valid sensor code |
| sensor_code | input | 8 | Temperature code from the sensor |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 1 | Level interrupt, OR of enabled status bits |

## Verification
The hardest case to reach is a falling event. It needs a level armed by an earlier sample at or above its threshold, followed by a sample below it. The stimulus table therefore walks the code upward through every rising threshold and then back down through every falling one, checking the status word accumulate one step at a time. Directed tests then line up a sample strobe and a clear write in the same cycle to show that a fresh event survives its own clear. They also count emulation strobes to show exactly where the substituted code takes over.

// File: rtl/thm_pkg.sv
package thm_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_READY = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_TEMP  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RISE  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_FALL  = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_INTEN = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_EMUL  = 8'h80;

    // enable, mode [15:13], gain [11:8], reference [28:24]
    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h1F00_EF01;

    localparam int LANE_STRIDE = 4;
    localparam int FALL_BASE   = 16;
    localparam int EMUL_CODE_LSB = 8;
    localparam int EMUL_DLY_LSB  = 16;

    function automatic logic [DATA_W-1:0] lane_mask(input int count, input int base);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < count; k++) m[base + LANE_STRIDE*k] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/thm_cross.sv
module thm_cross #(
    parameter int  CODE_W  = 8,
    parameter bit  RISING  = 1'b1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] thr,
    input  logic              at_or_above_q,
    output logic              at_or_above_d,
    output logic              hit
);
    logic ge;
    assign ge            = (code >= thr);
    assign at_or_above_d = ge;

    generate
        if (RISING) begin : g_up
            assign hit = ge & ~at_or_above_q;
        end else begin : g_down
            assign hit = ~ge & at_or_above_q;
        end
    endgenerate
endmodule

// File: rtl/thm_emul.sv
module thm_emul #(
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DELAY_W-1:0] delay,
    input  logic               tick,
    input  logic               enable,
    output logic               active
);
    logic [DELAY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = delay;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = enable && (cnt_q == '0);
endmodule

// File: rtl/thermal_irq_monitor.sv
module thermal_irq_monitor
    import thm_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int NUM_RISE = 4,
    parameter int NUM_FALL = 3,
    parameter int DELAY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [CODE_W-1:0] sensor_code,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] RISE_BITS = lane_mask(NUM_RISE, 0);
    localparam logic [DATA_W-1:0] FALL_BITS = lane_mask(NUM_FALL, FALL_BASE);
    localparam logic [DATA_W-1:0] IRQ_BITS  = RISE_BITS | FALL_BITS;

    typedef struct packed {
        logic [DATA_W-1:0]   ctrl;
        logic [DATA_W-1:0]   rise_thr;
        logic [DATA_W-1:0]   fall_thr;
        logic [DATA_W-1:0]   inten;
        logic [DATA_W-1:0]   stat;
        logic [DATA_W-1:0]   emul;
        logic [CODE_W-1:0]   temp;
        logic [NUM_RISE-1:0] up_ge;
        logic [NUM_FALL-1:0] dn_ge;
        logic                ready;
    } mon_state_t;

    mon_state_t s_d, s_q;

    logic              core_en;
    logic              emul_on;
    logic [CODE_W-1:0] eff_code;
    logic [NUM_RISE-1:0] up_hit, up_ge_d;
    logic [NUM_FALL-1:0] dn_hit, dn_ge_d;
    logic [DATA_W-1:0] evt_bits;
    logic              wr_emul;

    assign core_en  = s_q.ctrl[0];
    assign eff_code = emul_on ? s_q.emul[EMUL_CODE_LSB +: CODE_W] : sensor_code;
    assign wr_emul  = bus_wr && (bus_addr == OFS_EMUL) && bus_wdata[0];

    thm_emul #(.DELAY_W(DELAY_W)) u_emul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_emul),
        .delay  (bus_wdata[EMUL_DLY_LSB +: DELAY_W]),
        .tick   (sample_stb && core_en),
        .enable (s_q.emul[0]),
        .active (emul_on)
    );

    generate
        for (genvar i = 0; i < NUM_RISE; i++) begin : g_rise
            thm_cross #(.CODE_W(CODE_W), .RISING(1'b1)) u_cmp (
                .code          (eff_code),
                .thr           (s_q.rise_thr[CODE_W*i +: CODE_W]),
                .at_or_above_q (s_q.up_ge[i]),
                .at_or_above_d (up_ge_d[i]),
                .hit           (up_hit[i])
            );
        end
        for (genvar j = 0; j < NUM_FALL; j++) begin : g_fall
            thm_cross #(.CODE_W(CODE_W), .RISING(1'b0)) u_cmp (
                .code          (eff_code),
                .thr           (s_q.fall_thr[CODE_W*j +: CODE_W]),
                .at_or_above_q (s_q.dn_ge[j]),
                .at_or_above_d (dn_ge_d[j]),
                .hit           (dn_hit[j])
            );
        end
    endgenerate

    always_comb begin
        evt_bits = '0;
        for (int i = 0; i < NUM_RISE; i++) evt_bits[LANE_STRIDE*i] = up_hit[i];
        for (int j = 0; j < NUM_FALL; j++) evt_bits[FALL_BASE + LANE_STRIDE*j] = dn_hit[j];
    end

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b1;
        if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL:  s_d.ctrl     = bus_wdata & CTRL_KEEP;
                OFS_RISE:  s_d.rise_thr = bus_wdata;
                OFS_FALL:  s_d.fall_thr = bus_wdata;
                OFS_INTEN: s_d.inten    = bus_wdata & IRQ_BITS;
                OFS_CLR:   s_d.stat     = s_q.stat & ~(bus_wdata & IRQ_BITS);
                OFS_EMUL:  s_d.emul     = bus_wdata;
                default: ;
            endcase
        end
        if (sample_stb && core_en) begin
            s_d.temp  = eff_code;
            s_d.up_ge = up_ge_d;
            s_d.dn_ge = dn_ge_d;
            s_d.stat  = s_d.stat | evt_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = s_q.ctrl;
            OFS_READY: bus_rdata = DATA_W'(s_q.ready);
            OFS_TEMP:  bus_rdata = DATA_W'(s_q.temp);
            OFS_RISE:  bus_rdata = s_q.rise_thr;
            OFS_FALL:  bus_rdata = s_q.fall_thr;
            OFS_INTEN: bus_rdata = s_q.inten;
            OFS_STAT:  bus_rdata = s_q.stat;
            OFS_EMUL:  bus_rdata = s_q.emul;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(s_q.stat & s_q.inten);
endmodule

// File: rtl/thm_checker.sv
module thm_checker
    import thm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_stb,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              core_en,
    input logic [CODE_W-1:0] temp,
    input logic [DATA_W-1:0] stat,
    input logic [DATA_W-1:0] inten,
    input logic              ready
);
    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr == OFS_CLR);

    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ready);

    p_idle_core_holds_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> $stable(temp));

    p_ctrl_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata[1] == 1'b0));

    p_code_moves_only_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(temp));

    p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((stat & $past(stat)) == $past(stat)));

    p_no_enable_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inten == '0) |-> !irq);

    p_clear_takes_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !sample_stb) |=> ((stat & $past(bus_wdata)) == '0));
endmodule

bind thermal_irq_monitor thm_checker #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .core_en    (core_en),
    .temp       (s_q.temp),
    .stat       (s_q.stat),
    .inten      (s_q.inten),
    .ready      (s_q.ready)
);

// File: tb/sim_thermal_irq_monitor.sv
module sim_thermal_irq_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    localparam logic [7:0]  A_CTRL = 8'h20, A_RDY = 8'h28, A_TEMP = 8'h40,
                            A_RISE = 8'h50, A_FALL = 8'h54, A_EN = 8'h70,
                            A_STAT = 8'h74, A_CLR = 8'h78, A_EMUL = 8'h80;

    // code walks up through every rising threshold, then down through the falling ones
    localparam logic [7:0]  VEC_CODE [NVEC] = '{8'h50, 8'h65, 8'h75, 8'h95, 8'h70, 8'h50};
    localparam logic [31:0] VEC_STAT [NVEC] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0011,
                                                32'h0000_1111, 32'h0100_1111, 32'h0111_1111};
    localparam logic        VEC_IRQ  [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [7:0]  sensor_code = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    thermal_irq_monitor u0 (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .sensor_code(sensor_code),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic strobe(input logic [7:0] c);
        @(negedge clk);
        sample_stb = 1'b1; sensor_code = c;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic strobe_and_clear(input logic [7:0] c, input logic [31:0] m);
        @(negedge clk);
        sample_stb = 1'b1; sensor_code = c;
        bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = m;
        @(negedge clk);
        sample_stb = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_RDY, v);  chk("R1 ready", v, 32'h1);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_TEMP, v); chk("R1 temp", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 core disabled
        strobe(8'h99);
        rd(A_TEMP, v); chk("R2 temp held", v, 32'h0);
        rd(A_STAT, v); chk("R2 status held", v, 32'h0);

        // R3 control field mask
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R3 ctrl mask", v, 32'h1F00_EF01);
        wr(A_CTRL, 32'h0000_0001);

        wr(A_RISE, 32'h9080_7060);
        wr(A_FALL, 32'h0078_6858);
        wr(A_EN,   32'hFFFF_FFFF);
        rd(A_EN, v); chk("R7 enable mask", v, 32'h0111_1111);

        // R4 R5 R6 R7 table walk
        for (int k = 0; k < NVEC; k++) begin
            strobe(VEC_CODE[k]);
            rd(A_TEMP, v); chk("R4 temp", v, {24'b0, VEC_CODE[k]});
            rd(A_STAT, v); chk("R5 R6 status", v, VEC_STAT[k]);
            chk("R7 irq", {31'b0, irq}, {31'b0, VEC_IRQ[k]});
        end

        // R10 status write ignored, unmapped read zero
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R10 status write ignored", v, 32'h0111_1111);
        rd(8'h04, v);  chk("R10 unmapped", v, 32'h0);

        // R7 latch with enables clear
        wr(A_EN, 32'h0);
        chk("R7 irq masked", {31'b0, irq}, 32'h0);
        rd(A_STAT, v); chk("R7 status kept", v, 32'h0111_1111);
        wr(A_EN, 32'h0000_0001);
        chk("R7 irq single enable", {31'b0, irq}, 32'h1);

        // R8 partial clear
        wr(A_CLR, 32'h0000_0011);
        rd(A_STAT, v); chk("R8 partial clear", v, 32'h0111_1100);
        chk("R8 irq after clear", {31'b0, irq}, 32'h0);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R8 full clear", v, 32'h0);

        // R5 no retrigger while above
        strobe(8'h65);
        rd(A_STAT, v); chk("R5 rise again", v, 32'h0000_0001);
        wr(A_CLR, 32'h1);
        strobe(8'h66);
        rd(A_STAT, v); chk("R5 no retrigger", v, 32'h0);

        // R6 falling level 0 after armed
        strobe(8'h50);
        rd(A_STAT, v); chk("R6 fall0", v, 32'h0001_0000);
        wr(A_CLR, 32'hFFFF_FFFF);

        // R8 set wins over same-cycle clear
        strobe_and_clear(8'h65, 32'h0000_0001);
        rd(A_STAT, v); chk("R8 set beats clear", v, 32'h0000_0001);

        // R9 emulation with delay 2
        wr(A_EMUL, 32'h0002_A001);
        rd(A_EMUL, v); chk("R9 emul readback", v, 32'h0002_A001);
        strobe(8'h30);
        rd(A_TEMP, v); chk("R9 delay strobe 1", v, 32'h30);
        strobe(8'h31);
        rd(A_TEMP, v); chk("R9 delay strobe 2", v, 32'h31);
        strobe(8'h32);
        rd(A_TEMP, v); chk("R9 emulated code", v, 32'hA0);
        wr(A_EMUL, 32'h0002_A000);
        strobe(8'h33);
        rd(A_TEMP, v); chk("R9 emulation off", v, 32'h33);
        wr(A_EMUL, 32'h0000_B501);
        strobe(8'h34);
        rd(A_TEMP, v); chk("R9 zero delay", v, 32'hB5);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule